// File: doc/BRIEF.md
# Video Sync Word Filter and Detector

This block sits between the parallel video word input and the scrambler of a serial video transmit path. It latches one 10-bit word per clock. It marks words that belong to a timing reference (sync) preamble with an active-low strobe. On request, it also cleans the two low-order bits of those words, so that a source carrying only 8 significant bits still produces exact all-zero and all-one sync words. A 30-bit preamble therefore comes out correct.

A word counts as a sync word when its upper eight bits are all zero or all one. This covers the ranges 0x000–0x003 and 0x3FC–0x3FF, whatever the two low bits hold. The classification uses the word as it arrives, before any cleaning. When the transport-stream mode (the DVB-ASI mode) is selected, the block leaves every word alone and never raises the strobe. The cleaning stage is pure logic after the input register, so it adds no latency.

Top module: `sync_word_guard`

## Requirements
- R1: With `asi_mode` low, a word in 0x000–0x003 or 0x3FC–0x3FF drives `sync_seen_n` to 0.
- R2: With `asi_mode` low, any word outside those two ranges leaves `sync_seen_n` at 1.
- R3: `sync_seen_n` and `word_out` reflect the word captured at a rising edge, from that edge until the next one. A sync word followed by a non-sync word gives a low pulse exactly one clock long.
- R4: With `asi_mode` low and `keep_raw` low, words 0x000–0x003 leave as 0x000.
- R5: With `asi_mode` low and `keep_raw` low, words 0x3FC–0x3FF leave as 0x3FF.
- R6: With `keep_raw` high, every word leaves `word_out` unmodified.
- R7: With `asi_mode` high, `sync_seen_n` stays 1 and every word leaves unmodified, whatever the value of `keep_raw`.
- R8: A word outside the two sync ranges leaves unmodified in every mode.
- R9: After a synchronous reset, `sync_seen_n` is 1 and `word_out` is 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| word_in | input | 10 | Incoming video word |
| keep_raw | input | 1 | 1: pass sync words unchanged; 0: clean their low bits |
| asi_mode | input | 1 | 1: transport-stream mode, detection and cleaning disabled |
| sync_seen_n | output | 1 | Active-low sync word strobe, registered |
| word_out | output | 10 | Held word after optional cleaning, toward the scrambler |

## Verification
The held word and its captured mode flags are the only internal state. A wrong value in either shows at the ports in the first cycle after the edge that loaded it, as a bad strobe level or a wrong word toward the scrambler. No error stays hidden for more than one clock. The bench sweeps all 1024 codes under every combination of the two controls. It checks the strobe and the output word in every cycle, so a misplaced range boundary, a mis-cleaned low bit or a leak in transport-stream mode is caught on the first code that exercises it.

// File: rtl/sw_pkg.sv
package sw_pkg;
  typedef enum logic [1:0] {
    SW_PLAIN = 2'd0,
    SW_LOW   = 2'd1,
    SW_HIGH  = 2'd2
  } sw_class_e;
endpackage

// File: rtl/sw_classify.sv
module sw_classify
  import sw_pkg::*;
#(
  parameter int WORD_W  = 10,
  parameter int GUARD_W = 2
) (
  input  logic [WORD_W-1:0] word,
  output sw_class_e         cls
);
  localparam int HEAD_W = WORD_W - GUARD_W;

  logic [HEAD_W-1:0] head;
  assign head = word[WORD_W-1:GUARD_W];

  // Sync words are recognised on the upper bits only; the guard bits are don't-care.
  always_comb begin
    if (head == '0)      cls = SW_LOW;
    else if (&head)      cls = SW_HIGH;
    else                 cls = SW_PLAIN;
  end
endmodule

// File: rtl/sw_capture.sv
module sw_capture
  import sw_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_d,
  input  logic              keep_raw_d,
  input  logic              asi_d,
  input  sw_class_e         cls_d,
  output logic [WORD_W-1:0] word_q,
  output logic              keep_raw_q,
  output logic              asi_q,
  output logic              seen_n_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word_q     <= '0;
      keep_raw_q <= 1'b1;
      asi_q      <= 1'b1;
      seen_n_q   <= 1'b1;
    end else begin
      word_q     <= word_d;
      keep_raw_q <= keep_raw_d;
      asi_q      <= asi_d;
      seen_n_q   <= asi_d || (cls_d == SW_PLAIN);
    end
  end
endmodule

// File: rtl/sw_lowfix.sv
module sw_lowfix
  import sw_pkg::*;
#(
  parameter int WORD_W  = 10,
  parameter int GUARD_W = 2
) (
  input  logic [WORD_W-1:0] word,
  input  sw_class_e         cls,
  input  logic              fix_en,
  output logic [WORD_W-1:0] fixed
);
  logic force_bits;
  assign force_bits = fix_en && (cls != SW_PLAIN);

  assign fixed[WORD_W-1:GUARD_W] = word[WORD_W-1:GUARD_W];

  for (genvar i = 0; i < GUARD_W; i++) begin : g_guard
    assign fixed[i] = force_bits ? (cls == SW_HIGH) : word[i];
  end
endmodule

// File: rtl/sync_word_guard.sv
module sync_word_guard
  import sw_pkg::*;
#(
  parameter int WORD_W  = 10,
  parameter int GUARD_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_in,
  input  logic              keep_raw,
  input  logic              asi_mode,
  output logic              sync_seen_n,
  output logic [WORD_W-1:0] word_out
);
  sw_class_e         cls_in;
  sw_class_e         cls_held;
  logic [WORD_W-1:0] word_held;
  logic              keep_raw_held;
  logic              asi_held;

  sw_classify #(.WORD_W(WORD_W), .GUARD_W(GUARD_W)) u_cls_in (
    .word (word_in),
    .cls  (cls_in)
  );

  sw_capture #(.WORD_W(WORD_W)) u_cap (
    .clk        (clk),
    .rst        (rst),
    .word_d     (word_in),
    .keep_raw_d (keep_raw),
    .asi_d      (asi_mode),
    .cls_d      (cls_in),
    .word_q     (word_held),
    .keep_raw_q (keep_raw_held),
    .asi_q      (asi_held),
    .seen_n_q   (sync_seen_n)
  );

  sw_classify #(.WORD_W(WORD_W), .GUARD_W(GUARD_W)) u_cls_held (
    .word (word_held),
    .cls  (cls_held)
  );

  sw_lowfix #(.WORD_W(WORD_W), .GUARD_W(GUARD_W)) u_fix (
    .word   (word_held),
    .cls    (cls_held),
    .fix_en (!keep_raw_held && !asi_held),
    .fixed  (word_out)
  );
endmodule

// File: rtl/sync_word_guard_chk.sv
module sync_word_guard_chk #(
  parameter int WORD_W  = 10,
  parameter int GUARD_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] word_in,
  input logic              keep_raw,
  input logic              asi_mode,
  input logic              sync_seen_n,
  input logic [WORD_W-1:0] word_out
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  logic in_low, in_high;
  assign in_low  = (word_in[WORD_W-1:GUARD_W] == '0);
  assign in_high = (&word_in[WORD_W-1:GUARD_W]);

  a_r1_sync_flagged: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(asi_mode) && ($past(in_low) || $past(in_high)) |-> !sync_seen_n);

  a_r2_plain_quiet: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(in_low) && !$past(in_high) |-> sync_seen_n);

  a_r4_low_cleaned: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(asi_mode) && !$past(keep_raw) && $past(in_low) |-> word_out == '0);

  a_r5_high_cleaned: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(asi_mode) && !$past(keep_raw) && $past(in_high) |-> word_out == '1);

  a_r6_raw_pass: assert property (@(posedge clk) disable iff (rst)
    armed && $past(keep_raw) |-> word_out == $past(word_in));

  a_r7_asi_quiet: assert property (@(posedge clk) disable iff (rst)
    armed && $past(asi_mode) |-> sync_seen_n && word_out == $past(word_in));

  a_r8_plain_pass: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(in_low) && !$past(in_high) |-> word_out == $past(word_in));
endmodule

bind sync_word_guard sync_word_guard_chk #(.WORD_W(WORD_W), .GUARD_W(GUARD_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .word_in     (word_in),
  .keep_raw    (keep_raw),
  .asi_mode    (asi_mode),
  .sync_seen_n (sync_seen_n),
  .word_out    (word_out)
);

// File: tb/sim_sync_word_guard.sv
`timescale 1ns/1ps
module sim_sync_word_guard;
  logic       clk = 1'b0;
  logic       rst;
  logic [9:0] word_in;
  logic       keep_raw;
  logic       asi_mode;
  logic       sync_seen_n;
  logic [9:0] word_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  sync_word_guard u0 (
    .clk         (clk),
    .rst         (rst),
    .word_in     (word_in),
    .keep_raw    (keep_raw),
    .asi_mode    (asi_mode),
    .sync_seen_n (sync_seen_n),
    .word_out    (word_out)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  function automatic bit is_sync(input int w);
    return (w <= 3) || (w >= 1020);
  endfunction

  // Check outputs for word w captured with the given controls.
  task automatic check_word(input int w, input bit kr, input bit asi);
    int exp_w;
    int exp_n;
    string tag;
    exp_n = (!asi && is_sync(w)) ? 0 : 1;
    exp_w = w;
    if (!asi && !kr && w <= 3)    exp_w = 0;
    if (!asi && !kr && w >= 1020) exp_w = 1023;
    if (asi)              tag = "R7";
    else if (!is_sync(w)) tag = "R2/R8";
    else if (kr)          tag = "R1/R6";
    else if (w <= 3)      tag = "R1/R4";
    else                  tag = "R1/R5";
    check({tag, " strobe"}, int'(sync_seen_n), exp_n);
    check({tag, " word"}, int'(word_out), exp_w);
  endtask

  initial begin
    rst = 1'b1; word_in = 10'h155; keep_raw = 1'b0; asi_mode = 1'b0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 strobe", int'(sync_seen_n), 1);
    check("R9 word", int'(word_out), 0);
    rst = 1'b0;

    // R3: one-cycle strobe, sync word then plain word, outputs in the following cycle
    word_in = 10'h3FD;
    @(negedge clk);
    check("R3 strobe low", int'(sync_seen_n), 0);
    check("R3 word", int'(word_out), 10'h3FF);
    word_in = 10'h200;
    @(negedge clk);
    check("R3 strobe back high", int'(sync_seen_n), 1);
    check("R3 word next", int'(word_out), 10'h200);

    // Pipelined sweep: every code under all control combinations
    for (int m = 0; m < 4; m++) begin
      bit kr_prev, asi_prev;
      int w_prev;
      w_prev = -1; kr_prev = 0; asi_prev = 0;
      for (int w = 0; w < 1024; w++) begin
        word_in  = 10'(w);
        keep_raw = m[0];
        asi_mode = m[1];
        @(negedge clk);
        check_word(w, m[0], m[1]);
        w_prev = w; kr_prev = m[0]; asi_prev = m[1];
      end
    end

    // R7 explicit: transport mode with cleaning requested still leaves word raw
    word_in = 10'h001; keep_raw = 1'b0; asi_mode = 1'b1;
    @(negedge clk);
    check("R7 strobe", int'(sync_seen_n), 1);
    check("R7 word", int'(word_out), 10'h001);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule